// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns a 6-bit addressing-mode field into the address of one data access. The upper three bits of the field choose the addressing mode. The lower three bits choose one of eight address registers, and with it the offset register that has the same index. In the special mode, the lower three bits choose between an absolute address and an immediate operand instead. On each start strobe the unit produces a registered effective address and raises a one-cycle done pulse. When the mode asks for it, the unit also writes the updated address register back, either before or after the address is formed.

The register-select bits split the eight registers into two banks of four. The top bit chooses the bank and the lower two bits choose the register within it. All address arithmetic is plain 16-bit two's-complement arithmetic that wraps. A simple load port presets any address or offset register. When a load and a mode-driven update hit the same address register in the same cycle, the update wins. Modifier arithmetic (modulo, bit-reverse), decode of the rest of the instruction and the memory itself lie outside the unit.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset all address and offset registers are zero, and effAddr, immFlag, illegal and done are all 0.
- R2: Mode 000 outputs Rn and then sets Rn to Rn-Nn. Mode 001 outputs Rn and then sets Rn to Rn+Nn.
- R3: Mode 010 outputs Rn and then sets Rn to Rn-1. Mode 011 outputs Rn and then sets Rn to Rn+1.
- R4: Mode 100 outputs Rn and leaves every register unchanged.
- R5: Mode 101 outputs Rn+Nn and leaves Rn unchanged.
- R6: Mode 111 outputs Rn-1 and writes Rn-1 back into Rn.
- R7: Mode 110 with register bits 000 outputs extWord with immFlag=0. Mode 110 with register bits 100 outputs extWord with immFlag=1. Neither form changes any register.
- R8: Mode 110 with any other register bits sets illegal=1, immFlag=0 and effAddr=0, and changes no register.
- R9: Register bits {b2,b1,b0} select register number 4*b2 + 2*b1 + b0. b2=0 is the low bank R0..R3 and b2=1 is the high bank R4..R7. Nn always uses the same index as Rn.
- R10: All address arithmetic wraps modulo 2^16: 0-1 gives 0xFFFF and 0xFFFF+1 gives 0.
- R11: With ldEn=1, ldData is written at the next clock edge into Rn (ldSel=0) or Nn (ldSel=1), where n is ldIdx. If a mode update writes the same Rn in that cycle, the update is kept and the load is dropped. Loads to any other register still take effect.
- R12: done is 1 exactly in the cycle after each cycle that has start=1, and 0 otherwise. effAddr, immFlag and illegal change only after a start and hold their values between starts. Starts may come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one address computation this cycle |
| modeField | input | 6 | Mode bits [5:3], register-select bits [2:0] |
| extWord | input | ADDR_W | Extension word for the absolute and immediate forms |
| ldEn | input | 1 | Load-port write enable |
| ldSel | input | 1 | 0 loads an address register, 1 loads an offset register |
| ldIdx | input | 3 | Index of the register to load |
| ldData | input | ADDR_W | Load-port data |
| effAddr | output | ADDR_W | Registered effective address or immediate data |
| immFlag | output | 1 | effAddr holds immediate data |
| illegal | output | 1 | The last mode field was an illegal code |
| done | output | 1 | One-cycle pulse after each start |

## Verification
The bench builds the unit with the default ADDR_W of 16. At that width the wrap points 0x0000 and 0xFFFF can be reached in one load and one step, so decrement, increment, offset add and predecrement are each driven across the wrap. All eight registers are loaded with distinct values, so a wrong bank or slot decode shows up as a wrong address. The bench also lands loads on the same cycle as updates, both to the register being updated and to other registers, which covers the load-port priority.

// File: rtl/effa_pkg.sv
package effa_pkg;

  localparam int MODE_BITS = 3;
  localparam int REG_BITS  = 3;
  localparam int NUM_REG   = 1 << REG_BITS;
  localparam int FIELD_W   = MODE_BITS + REG_BITS;

  // Mode codes: the encoding is the behaviour, so the values are fixed.
  typedef enum logic [MODE_BITS-1:0] {
    MD_POST_SUBN = 3'b000,
    MD_POST_ADDN = 3'b001,
    MD_POST_DEC  = 3'b010,
    MD_POST_INC  = 3'b011,
    MD_PLAIN     = 3'b100,
    MD_INDEXED   = 3'b101,
    MD_SPECIAL   = 3'b110,
    MD_PRE_DEC   = 3'b111
  } modeE;

  localparam logic [REG_BITS-1:0] SPC_ABS = 3'b000;
  localparam logic [REG_BITS-1:0] SPC_IMM = 3'b100;

  typedef enum logic [1:0] {
    AS_REG,
    AS_REG_N,
    AS_REG_M1,
    AS_EXT
  } addrSrcE;

  typedef enum logic [1:0] {
    UP_MINUS_N,
    UP_PLUS_N,
    UP_MINUS_1,
    UP_PLUS_1
  } updOpE;

  typedef struct packed {
    logic    fire;
    logic    regWr;
    updOpE   updOp;
    addrSrcE addrSrc;
    logic    imm;
    logic    illegal;
  } ctrlS;

endpackage

// File: rtl/effa_ctrl.sv
module effa_ctrl
  import effa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [FIELD_W-1:0] modeField,
  output ctrlS               ctl,
  output logic               done,
  output logic               immFlag,
  output logic               illegal
);

  modeE                mode;
  logic [REG_BITS-1:0] regBits;
  logic                wantWr;

  assign mode    = modeE'(modeField[FIELD_W-1:REG_BITS]);
  assign regBits = modeField[REG_BITS-1:0];

  // Turn the mode field into strobes for the datapath.
  always_comb begin
    ctl         = '0;
    wantWr      = 1'b0;
    ctl.fire    = start;
    ctl.updOp   = UP_MINUS_N;
    ctl.addrSrc = AS_REG;
    case (mode)
      MD_POST_SUBN: begin wantWr = 1'b1; ctl.updOp = UP_MINUS_N; end
      MD_POST_ADDN: begin wantWr = 1'b1; ctl.updOp = UP_PLUS_N;  end
      MD_POST_DEC:  begin wantWr = 1'b1; ctl.updOp = UP_MINUS_1; end
      MD_POST_INC:  begin wantWr = 1'b1; ctl.updOp = UP_PLUS_1;  end
      MD_PLAIN:     ctl.addrSrc = AS_REG;
      MD_INDEXED:   ctl.addrSrc = AS_REG_N;
      MD_PRE_DEC: begin
        wantWr      = 1'b1;
        ctl.updOp   = UP_MINUS_1;
        ctl.addrSrc = AS_REG_M1;
      end
      MD_SPECIAL: begin
        ctl.addrSrc = AS_EXT;
        if (regBits == SPC_IMM)      ctl.imm     = 1'b1;
        else if (regBits != SPC_ABS) ctl.illegal = 1'b1;
      end
      default: ctl.addrSrc = AS_REG;
    endcase
    ctl.regWr = start & wantWr;
  end

  // Registered status outputs; they hold between starts.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      immFlag <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        immFlag <= ctl.imm;
        illegal <= ctl.illegal;
      end
    end
  end

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);                                                   // R12
  AST_DONE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);                                                 // R12
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(immFlag) && $stable(illegal)));                // R12
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(immFlag && illegal));                                            // R8

endmodule

// File: rtl/effa_datapath.sv
module effa_datapath
  import effa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlS                ctl,
  input  logic [REG_BITS-1:0] regBits,
  input  logic [ADDR_W-1:0]   extWord,
  input  logic                ldEn,
  input  logic                ldSel,
  input  logic [REG_BITS-1:0] ldIdx,
  input  logic [ADDR_W-1:0]   ldData,
  output logic [ADDR_W-1:0]   effAddr
);

  localparam int SLOT_BITS = REG_BITS - 1;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0]   rArr [NUM_REG];
  logic [ADDR_W-1:0]   nArr [NUM_REG];
  logic                bankSel;
  logic [SLOT_BITS-1:0] slotSel;
  logic [REG_BITS-1:0] regIdx;
  logic [ADDR_W-1:0]   rCur, nCur, updVal, addrVal;
  logic [NUM_REG-1:0]  rUpdHit, rLdHit, nLdHit;

  // The top bit picks the bank, the low bits pick the slot within it.
  assign bankSel = regBits[REG_BITS-1];
  assign slotSel = regBits[SLOT_BITS-1:0];
  assign regIdx  = {bankSel, slotSel};

  assign rCur = rArr[regIdx];
  assign nCur = nArr[regIdx];

  always_comb begin
    case (ctl.updOp)
      UP_MINUS_N: updVal = rCur - nCur;
      UP_PLUS_N:  updVal = rCur + nCur;
      UP_MINUS_1: updVal = rCur - ONE;
      default:    updVal = rCur + ONE;
    endcase
  end

  always_comb begin
    case (ctl.addrSrc)
      AS_REG:    addrVal = rCur;
      AS_REG_N:  addrVal = rCur + nCur;
      AS_REG_M1: addrVal = rCur - ONE;
      default:   addrVal = extWord;
    endcase
  end

  for (genvar i = 0; i < NUM_REG; i++) begin : g_hit
    assign rUpdHit[i] = ctl.regWr && (regIdx == REG_BITS'(i));
    assign rLdHit[i]  = ldEn && !ldSel && (ldIdx == REG_BITS'(i));
    assign nLdHit[i]  = ldEn &&  ldSel && (ldIdx == REG_BITS'(i));
  end

  // A mode update takes priority over a load of the same address register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REG; i++) begin
        rArr[i] <= '0;
        nArr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_REG; i++) begin
        if (rUpdHit[i])     rArr[i] <= updVal;
        else if (rLdHit[i]) rArr[i] <= ldData;
        if (nLdHit[i])      nArr[i] <= ldData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         effAddr <= '0;
    else if (ctl.fire) effAddr <= ctl.illegal ? '0 : addrVal;
  end

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.illegal |-> !ctl.regWr);                                       // R8
  AST_PLAIN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.addrSrc == AS_REG) |=> effAddr == $past(rCur));   // R2
  AST_INDEXED_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.addrSrc == AS_REG_N)
      |=> effAddr == $past(rCur + nCur));                              // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.fire |=> $stable(effAddr));                                   // R12
  AST_UPDATE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.regWr && ldEn && !ldSel && ldIdx == regIdx)
      |=> rArr[$past(regIdx)] == $past(updVal));                       // R11
  AST_NO_UPDATE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && !ctl.regWr && !(ldEn && !ldSel))
      |=> rArr[$past(regIdx)] == $past(rCur));                         // R4

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import effa_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [5:0]         modeField,
  input  logic [ADDR_W-1:0]  extWord,
  input  logic               ldEn,
  input  logic               ldSel,
  input  logic [2:0]         ldIdx,
  input  logic [ADDR_W-1:0]  ldData,
  output logic [ADDR_W-1:0]  effAddr,
  output logic               immFlag,
  output logic               illegal,
  output logic               done
);

  ctrlS ctl;

  effa_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeField (modeField),
    .ctl       (ctl),
    .done      (done),
    .immFlag   (immFlag),
    .illegal   (illegal)
  );

  effa_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .regBits (modeField[REG_BITS-1:0]),
    .extWord (extWord),
    .ldEn    (ldEn),
    .ldSel   (ldSel),
    .ldIdx   (ldIdx),
    .ldData  (ldData),
    .effAddr (effAddr)
  );

endmodule

// File: tb/tb_eff_addr_unit.sv
`timescale 1ns/1ps
module tb_eff_addr_unit;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          start;
  logic [5:0]    modeField;
  logic [AW-1:0] extWord;
  logic          ldEn, ldSel;
  logic [2:0]    ldIdx;
  logic [AW-1:0] ldData;
  logic [AW-1:0] effAddr;
  logic          immFlag, illegal, done;

  always #2 clk = ~clk;

  eff_addr_unit #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .start(start), .modeField(modeField),
    .extWord(extWord), .ldEn(ldEn), .ldSel(ldSel), .ldIdx(ldIdx),
    .ldData(ldData), .effAddr(effAddr), .immFlag(immFlag),
    .illegal(illegal), .done(done)
  );

  logic [AW-1:0] mR [8];
  logic [AW-1:0] mN [8];
  logic [AW+1:0] expQ [$];
  string         tagQ [$];
  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic loadReg(input bit sel, input logic [2:0] idx,
                         input logic [AW-1:0] d);
    ldEn = 1'b1; ldSel = sel; ldIdx = idx; ldData = d;
    @(posedge clk); #1;
    ldEn = 1'b0;
    if (sel) mN[idx] = d; else mR[idx] = d;
  endtask

  // Driver: model the operation, push the expected item, drive one start.
  task automatic issue(input logic [2:0] md, input logic [2:0] rs,
                       input logic [AW-1:0] ext, input string tag,
                       input bit withLd = 1'b0, input bit lSel = 1'b0,
                       input logic [2:0] lIdx = 3'd0,
                       input logic [AW-1:0] lData = '0);
    logic [AW-1:0] r, n, a;
    bit im, il, wr;
    r = mR[rs]; n = mN[rs]; im = 1'b0; il = 1'b0; wr = 1'b1; a = r;
    case (md)
      3'b000: mR[rs] = r - n;
      3'b001: mR[rs] = r + n;
      3'b010: mR[rs] = r - 16'd1;
      3'b011: mR[rs] = r + 16'd1;
      3'b100: wr = 1'b0;
      3'b101: begin wr = 1'b0; a = r + n; end
      3'b110: begin
        wr = 1'b0;
        if (rs == 3'b000)      a = ext;
        else if (rs == 3'b100) begin a = ext; im = 1'b1; end
        else begin a = '0; il = 1'b1; end
      end
      default: begin a = r - 16'd1; mR[rs] = a; end
    endcase
    if (withLd) begin
      if (lSel) mN[lIdx] = lData;
      else if (!(wr && lIdx == rs)) mR[lIdx] = lData;
    end
    expQ.push_back({im, il, a});
    tagQ.push_back(tag);
    start = 1'b1; modeField = {md, rs}; extWord = ext;
    ldEn = withLd; ldSel = lSel; ldIdx = lIdx; ldData = lData;
    @(posedge clk); #1;
    start = 1'b0; ldEn = 1'b0;
  endtask

  // Monitor: compare each done against the oldest expected item.
  always @(negedge clk) begin
    if (rstN === 1'b1 && done === 1'b1) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R12", "done without start", 32'(done), 32'd0);
      end else begin
        logic [AW+1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(effAddr === e[AW-1:0], t, "effAddr", 32'(effAddr), 32'(e[AW-1:0]));
        chk(immFlag === e[AW+1], t, "immFlag", 32'(immFlag), 32'(e[AW+1]));
        chk(illegal === e[AW], t, "illegal", 32'(illegal), 32'(e[AW]));
      end
    end
  end

  initial begin
    #800000;
    chk(1'b0, "R12", "watchdog expired", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; modeField = '0; extWord = '0;
    ldEn = 1'b0; ldSel = 1'b0; ldIdx = '0; ldData = '0;
    for (int i = 0; i < 8; i++) begin mR[i] = '0; mN[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs after reset
    chk(effAddr === '0, "R1", "effAddr at reset", 32'(effAddr), 32'd0);
    chk(done === 1'b0, "R1", "done at reset", 32'(done), 32'd0);
    chk(immFlag === 1'b0 && illegal === 1'b0, "R1", "flags at reset",
        32'({immFlag, illegal}), 32'd0);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1: every address register reads back as zero
    for (int i = 0; i < 8; i++) issue(3'b100, 3'(i), '0, "R1");
    issue(3'b101, 3'd3, '0, "R1");
    // R11: load every register, R9: all distinct so the decode is visible
    for (int i = 0; i < 8; i++) begin
      loadReg(1'b0, 3'(i), 16'h1000 * 16'(i + 1) + 16'h0010);
      loadReg(1'b1, 3'(i), 16'(3 * i + 2));
    end
    for (int i = 0; i < 8; i++) issue(3'b100, 3'(i), '0, "R9");
    issue(3'b100, 3'd5, '0, "R4");
    issue(3'b100, 3'd5, '0, "R4");
    issue(3'b101, 3'd6, '0, "R5");
    issue(3'b100, 3'd6, '0, "R5");
    issue(3'b000, 3'd1, '0, "R2");
    issue(3'b100, 3'd1, '0, "R2");
    issue(3'b001, 3'd2, '0, "R2");
    issue(3'b001, 3'd2, '0, "R2");
    issue(3'b010, 3'd3, '0, "R3");
    issue(3'b011, 3'd4, '0, "R3");
    issue(3'b100, 3'd3, '0, "R3");
    issue(3'b100, 3'd4, '0, "R3");
    issue(3'b111, 3'd7, '0, "R6");
    issue(3'b111, 3'd7, '0, "R6");
    issue(3'b100, 3'd7, '0, "R6");
    issue(3'b110, 3'b000, 16'hBEEF, "R7");
    issue(3'b110, 3'b100, 16'h1234, "R7");
    for (int i = 0; i < 8; i++) issue(3'b100, 3'(i), '0, "R7");
    issue(3'b110, 3'b001, 16'h5555, "R8");
    issue(3'b110, 3'b010, 16'h6666, "R8");
    issue(3'b110, 3'b111, 16'h7777, "R8");
    issue(3'b110, 3'b101, 16'h8888, "R8");
    for (int i = 0; i < 8; i++) issue(3'b100, 3'(i), '0, "R8");
    // R10: wrap in both directions
    loadReg(1'b0, 3'd3, 16'h0000);
    issue(3'b010, 3'd3, '0, "R10");
    issue(3'b100, 3'd3, '0, "R10");
    loadReg(1'b0, 3'd4, 16'hFFFF);
    issue(3'b011, 3'd4, '0, "R10");
    issue(3'b100, 3'd4, '0, "R10");
    loadReg(1'b0, 3'd0, 16'hFFF0);
    loadReg(1'b1, 3'd0, 16'h0020);
    issue(3'b101, 3'd0, '0, "R10");
    issue(3'b001, 3'd0, '0, "R10");
    issue(3'b000, 3'd0, '0, "R10");
    issue(3'b100, 3'd0, '0, "R10");
    loadReg(1'b0, 3'd2, 16'h0000);
    issue(3'b111, 3'd2, '0, "R10");
    issue(3'b100, 3'd2, '0, "R10");
    // R11: update beats a same-cycle load of the same register
    issue(3'b011, 3'd5, '0, "R11", 1'b1, 1'b0, 3'd5, 16'hAAAA);
    issue(3'b100, 3'd5, '0, "R11");
    // R11: a load of another register in an update cycle still lands
    issue(3'b010, 3'd5, '0, "R11", 1'b1, 1'b0, 3'd6, 16'h4321);
    issue(3'b100, 3'd6, '0, "R11");
    issue(3'b100, 3'd5, '0, "R11");
    // R11: offset load in the same cycle is seen only from the next op
    issue(3'b001, 3'd1, '0, "R11", 1'b1, 1'b1, 3'd1, 16'h0100);
    issue(3'b001, 3'd1, '0, "R11");
    issue(3'b100, 3'd1, '0, "R11");
    // R11: a load to the same register under a non-updating mode lands
    issue(3'b100, 3'd7, '0, "R11", 1'b1, 1'b0, 3'd7, 16'h0BAD);
    issue(3'b100, 3'd7, '0, "R11");
    // R12: idle gap, outputs must hold and done stay low
    repeat (4) @(posedge clk);
    #1;
    chk(effAddr === 16'h0BAD, "R12", "effAddr hold", 32'(effAddr), 32'h0BAD);
    chk(done === 1'b0, "R12", "done idle", 32'(done), 32'd0);
    issue(3'b110, 3'b100, 16'h0042, "R12");
    repeat (3) @(posedge clk);
    #1;
    chk(immFlag === 1'b1, "R12", "immFlag hold", 32'(immFlag), 32'd1);
    chk(expQ.size() == 0, "R12", "missing done", 32'(expQ.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule